// File: doc/BRIEF.md
# Registered ROM with Initialize Word

This block is a read-only store of 1024 bytes with a register on its read path. On each rising clock edge the byte at the presented address is captured into an output register. That register drives the data outputs. Once the edge has passed, the address may move to the next location while the captured byte stays put. Two active-low enables control visibility, and they act differently. The synchronous one is sampled into a flip-flop on the clock edge. The asynchronous one gates the outputs at once, with no clock involved.

A separate stored byte, the initialize word, can be forced into the output register at any moment by holding an active-low initialize input. This does not depend on the clock. It lets a system start from a chosen jump-start value instead of a fixed reset value. An unwritten initialize word is all zeros, so initialize then clears the register. An initialize word of all ones makes it a preset.

The tri-state output is modelled as a data bus plus an output-valid flag. Contents are written through a synchronous preload port. A simulation power-on input puts the enable flip-flop in its disabling state, as at power-up.

Top module: `rrom_registered`

## Requirements
- R1: After power-on (`por_n` LOW, then HIGH), `q_oe` stays 0 until a rising edge samples `sync_en_n` = 0.
- R2: A rising edge with `init_n` = 1 loads the array byte at `addr` into the output register. While `q_oe` = 1, `q` shows that byte.
- R3: `async_en_n` = 1 forces `q_oe` = 0 and `q` = 0 at once, with no clock. Returning it to 0 restores the output at once if the enable flip-flop allows it.
- R4: `sync_en_n` = 1 at a rising edge makes `q_oe` = 0 after that edge, whatever the value of `async_en_n`.
- R5: Changes of `addr` and `sync_en_n` between edges leave `q` and `q_oe` unchanged until the next rising edge.
- R6: `init_n` = 0 loads the initialize word into the output register at once, without a clock. While `init_n` stays 0, rising edges leave that value in place.
- R7: Initialize never sets `q_oe`. Output is visible only after an edge has sampled `sync_en_n` = 0 and while `async_en_n` = 0.
- R8: After power-on the initialize word is 8'h00, so initialize clears the register. Once 8'hFF is written, initialize presets it to all ones.
- R9: The first rising edge after `init_n` returns to 1 loads array data normally.
- R10: On a rising edge with `pre_we` = 1, `pre_data` is written to the array at `pre_addr` when `pre_init` = 0, or to the initialize word when `pre_init` = 1. Reads see the new value from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| por_n | input | 1 | Simulation power-on, active low, disables outputs and resets the initialize word |
| pre_we | input | 1 | Preload write strobe |
| pre_init | input | 1 | Preload target: 1 = initialize word, 0 = array |
| pre_addr | input | 10 | Preload array address |
| pre_data | input | 8 | Preload data |
| addr | input | 10 | Read address |
| sync_en_n | input | 1 | Synchronous output enable, active low, sampled on the edge |
| async_en_n | input | 1 | Asynchronous output enable, active low |
| init_n | input | 1 | Asynchronous initialize, active low |
| q | output | 8 | Registered data, zero while not driven |
| q_oe | output | 1 | Output valid, stands in for the tri-state drivers |

## Verification
The hardest state to reach is initialize held across clock edges while the outputs become enabled. This shows the initialize word on the bus without any array read. It is reached in a fixed order: disable the outputs, pull initialize low in mid-cycle, clock with the synchronous enable low, then open the asynchronous enable. The stimulus also checks, between edges, that initialize alone never enables the outputs. A seeded random phase then mixes address, both enables and full-cycle initialize pulses, checked against a bench model.

// File: rtl/rrom_pkg.sv
package rrom_pkg;
   // state of the synchronous enable flip-flop
   typedef enum logic {
      EN_DRIVE = 1'b0,
      EN_HIZ   = 1'b1
   } en_state_e;
endpackage

// File: rtl/rrom_array.sv
module rrom_array #(
   parameter int unsigned ADDR_W       = 10,
   parameter int unsigned DATA_W       = 8,
   parameter logic [DATA_W-1:0] INIT_DEFAULT = '0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              pre_we,
   input  logic              pre_init,
   input  logic [ADDR_W-1:0] pre_addr,
   input  logic [DATA_W-1:0] pre_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] init_word
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];
   logic [DATA_W-1:0] init_q;

   always_ff @(posedge clk) begin
      if (pre_we && !pre_init) store[pre_addr] <= pre_data;
   end

   // unwritten initialize word equals INIT_DEFAULT (all zeros = clear)
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                 init_q <= INIT_DEFAULT;
      else if (pre_we && pre_init) init_q <= pre_data;
   end

   assign rd_word   = store[rd_addr];
   assign init_word = init_q;
endmodule

// File: rtl/rrom_enable.sv
module rrom_enable
   import rrom_pkg::*;
(
   input  logic      clk,
   input  logic      por_n,
   input  logic      sync_en_n,
   output en_state_e state_q
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         state_q <= EN_HIZ;
      else if (sync_en_n) state_q <= EN_HIZ;
      else                state_q <= EN_DRIVE;
   end
endmodule

// File: rtl/rrom_outreg.sv
module rrom_outreg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              init_n,
   input  logic [DATA_W-1:0] init_word,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   // asynchronous load of the stored initialize word, held while init_n is low
   always_ff @(posedge clk or negedge init_n) begin
      if (!init_n) q <= init_word;
      else         q <= d;
   end
endmodule

// File: rtl/rrom_registered.sv
module rrom_registered
   import rrom_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] INIT_DEFAULT = '0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              pre_we,
   input  logic              pre_init,
   input  logic [ADDR_W-1:0] pre_addr,
   input  logic [DATA_W-1:0] pre_data,
   input  logic [ADDR_W-1:0] addr,
   input  logic              sync_en_n,
   input  logic              async_en_n,
   input  logic              init_n,
   output logic [DATA_W-1:0] q,
   output logic              q_oe
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("rrom_registered: ADDR_W out of range 1..12");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("rrom_registered: DATA_W must be positive");
   end

   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] init_word;
   logic [DATA_W-1:0] data_q;
   en_state_e         en_state;

   rrom_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_DEFAULT(INIT_DEFAULT)
   ) u_array (
      .clk(clk), .por_n(por_n), .pre_we(pre_we), .pre_init(pre_init),
      .pre_addr(pre_addr), .pre_data(pre_data), .rd_addr(addr),
      .rd_word(rd_word), .init_word(init_word)
   );

   rrom_enable u_enable (
      .clk(clk), .por_n(por_n), .sync_en_n(sync_en_n), .state_q(en_state)
   );

   rrom_outreg #(.DATA_W(DATA_W)) u_outreg (
      .clk(clk), .init_n(init_n), .init_word(init_word),
      .d(rd_word), .q(data_q)
   );

   assign q_oe = (en_state == EN_DRIVE) && !async_en_n;

   // per-bit gating stands in for the tri-state drivers
   for (genvar b = 0; b < DATA_W; b++) begin : g_gate
      assign q[b] = data_q[b] & q_oe;
   end
endmodule

// File: rtl/rrom_checker.sv
module rrom_checker #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              por_n,
   input logic              sync_en_n,
   input logic              async_en_n,
   input logic              init_n,
   input logic [DATA_W-1:0] q,
   input logic              q_oe,
   input logic [DATA_W-1:0] rd_word,
   input logic [DATA_W-1:0] init_word
);
   logic seen;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   a_r3_async_off: assert property (@(posedge clk) disable iff (!por_n)
      async_en_n |-> !q_oe);

   a_r3_zero_when_off: assert property (@(posedge clk) disable iff (!por_n)
      !q_oe |-> (q == '0));

   a_r4_sync_off: assert property (@(posedge clk) disable iff (!por_n)
      sync_en_n |=> !q_oe);

   // R1 and R7: visible output needs an edge that sampled sync enable low
   a_r7_enable_needs_sync: assert property (@(posedge clk) disable iff (!por_n)
      (seen && q_oe) |-> $past(!sync_en_n));

   a_r6_init_value: assert property (@(posedge clk) disable iff (!por_n)
      (!init_n && q_oe) |-> (q == init_word));

   a_r2_array_read: assert property (@(posedge clk) disable iff (!por_n)
      (seen && q_oe && init_n && $past(init_n)) |-> (q == $past(rd_word)));
endmodule

bind rrom_registered rrom_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .por_n(por_n), .sync_en_n(sync_en_n), .async_en_n(async_en_n),
   .init_n(init_n), .q(q), .q_oe(q_oe), .rd_word(rd_word), .init_word(init_word)
);

// File: tb/tb_rrom_registered.sv
module tb_rrom_registered;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       pre_we = 1'b0;
   logic       pre_init = 1'b0;
   logic [9:0] pre_addr = '0;
   logic [7:0] pre_data = '0;
   logic [9:0] addr = '0;
   logic       sync_en_n = 1'b1;
   logic       async_en_n = 1'b1;
   logic       init_n = 1'b1;
   logic [7:0] q;
   logic       q_oe;

   int n_chk = 0;
   int n_fail = 0;

   // bench model
   logic [7:0] m_mem [1024];
   logic [7:0] m_init = 8'h00;
   logic [7:0] m_reg = 8'h00;
   logic       m_dis = 1'b1;

   rrom_registered dut (
      .clk(clk), .por_n(por_n), .pre_we(pre_we), .pre_init(pre_init),
      .pre_addr(pre_addr), .pre_data(pre_data), .addr(addr),
      .sync_en_n(sync_en_n), .async_en_n(async_en_n), .init_n(init_n),
      .q(q), .q_oe(q_oe)
   );

   always #10 clk = ~clk;

   function automatic logic [7:0] pat(input logic [9:0] a);
      return (a[7:0] * 8'd29) ^ {a[9:8], a[9:4]} ^ 8'hA5;
   endfunction

   function automatic logic exp_oe();
      return !m_dis && !async_en_n;
   endfunction

   function automatic logic [7:0] exp_q();
      return exp_oe() ? m_reg : 8'h00;
   endfunction

   task automatic chk8(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s q: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic chk1(input string tag, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s q_oe: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic check_now(input string tag);
      chk1(tag, q_oe, exp_oe());
      chk8(tag, q, exp_q());
   endtask

   // drive at the falling edge, check mid-cycle, clock, check after the edge
   task automatic cyc(input logic [9:0] a, input logic s, input logic e,
                      input logic i, input string tmid, input string tpost);
      @(negedge clk);
      addr = a; sync_en_n = s; async_en_n = e; init_n = i;
      #1;
      if (!i) m_reg = m_init;
      check_now(tmid);
      @(posedge clk);
      m_reg = i ? m_mem[a] : m_init;
      m_dis = s;
      #1;
      check_now(tpost);
   endtask

   task automatic pload(input logic isinit, input logic [9:0] a, input logic [7:0] d);
      @(negedge clk);
      pre_we = 1'b1; pre_init = isinit; pre_addr = a; pre_data = d;
      addr = a; sync_en_n = 1'b1;
      @(posedge clk);
      if (isinit) m_init = d; else m_mem[a] = d;
      m_dis = 1'b1;
      @(negedge clk);
      pre_we = 1'b0; pre_init = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240));
      #3;
      chk1("R1 power-on", q_oe, 1'b0);
      chk8("R1 power-on", q, 8'h00);
      @(negedge clk); por_n = 1'b1;

      // R10: fill the array through the preload port
      for (int a = 0; a < 1024; a++) pload(1'b0, 10'(a), pat(10'(a)));

      // R1: clocks with sync disabled keep outputs off even with async enabled
      cyc(10'd5, 1'b1, 1'b0, 1'b1, "R1", "R1");
      cyc(10'd6, 1'b1, 1'b0, 1'b1, "R1", "R1");
      // R2: enable and read
      cyc(10'd100, 1'b0, 1'b0, 1'b1, "R1", "R2");
      chk8("R2 read 100", q, pat(10'd100));
      cyc(10'd1023, 1'b0, 1'b0, 1'b1, "R5", "R2");
      chk8("R2 read 1023", q, pat(10'd1023));
      // R5: address and sync change mid-cycle, output held until the edge
      cyc(10'd0, 1'b1, 1'b0, 1'b1, "R5", "R4");
      chk1("R4 sync off", q_oe, 1'b0);
      cyc(10'd0, 1'b0, 1'b0, 1'b1, "R1", "R2");
      chk8("R2 read 0", q, pat(10'd0));
      // R3: async disable/enable without a clock
      cyc(10'd7, 1'b0, 1'b1, 1'b1, "R3", "R3");
      chk1("R3 async off", q_oe, 1'b0);
      cyc(10'd8, 1'b0, 1'b0, 1'b1, "R3", "R2");
      // R4: sync high at the edge with async low
      cyc(10'd9, 1'b1, 1'b0, 1'b1, "R5", "R4");
      // R6/R8: clear from the default word, mid-cycle, then held across edges
      cyc(10'd10, 1'b0, 1'b0, 1'b1, "R4", "R2");
      cyc(10'd11, 1'b0, 1'b0, 1'b0, "R6", "R6");
      chk8("R8 clear", q, 8'h00);
      cyc(10'd12, 1'b0, 1'b0, 1'b0, "R6", "R6");
      chk8("R6 held over edge", q, 8'h00);
      // R9: first edge after release reads the array
      cyc(10'd13, 1'b0, 1'b0, 1'b1, "R9", "R9");
      chk8("R9 after release", q, pat(10'd13));
      // R10/R8: program all ones as the initialize word, overwrite a byte
      pload(1'b1, 10'd0, 8'hFF);
      pload(1'b0, 10'd300, 8'h3C);
      // R7: initialize while disabled leaves outputs off
      cyc(10'd300, 1'b1, 1'b0, 1'b0, "R7", "R7");
      chk1("R7 init no enable", q_oe, 1'b0);
      // enable with initialize still held: preset visible, no array read
      cyc(10'd300, 1'b0, 1'b1, 1'b0, "R7", "R7");
      cyc(10'd300, 1'b0, 1'b0, 1'b0, "R8", "R8");
      chk8("R8 preset", q, 8'hFF);
      cyc(10'd300, 1'b0, 1'b0, 1'b1, "R9", "R10");
      chk8("R10 rewritten byte", q, 8'h3C);

      // random phase
      for (int k = 0; k < 400; k++) begin
         logic [9:0] ra;
         logic rs, re, ri;
         ra = 10'($urandom % 1024);
         rs = ($urandom % 8) == 0;
         re = ($urandom % 6) == 0;
         ri = ($urandom % 10) != 0;
         cyc(ra, rs, re, ri, "R5", "R2");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule